// File: doc/BRIEF.md
# Programmable Baud16 Tick Generator

This block turns a reference clock into the oversampling time base of a serial port. A 16-bit down counter runs on the reference clock. When it reaches zero it emits a tick one reference cycle wide and loads the divisor again. A divisor of D therefore gives one tick every D+1 reference cycles. To reach sixteen ticks per serial bit, software picks D = f_ref / (16 × baud) − 1. For example, a 7.3728 MHz reference at 9600 baud needs D = 47.

Software writes the divisor as two bytes, each through its own 8-bit write port. The counter reads a new divisor only when it reloads, so a write never shortens or stretches the period already under way. A second stage counts ticks and raises a bit-rate strobe on every sixteenth tick, for use by the transmitter. While the enable is low, the counter sits at the divisor value and both outputs stay low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both outputs are low, the divisor high byte is 0 and the low byte is the parameter `LO_RESET` (default 0).
- R2: A strobe on `div_lo_we` loads `div_lo_wdata` into divisor bits 7:0, and a strobe on `div_hi_we` loads `div_hi_wdata` into bits 15:8. Each load happens at the next clock edge and leaves the other byte unchanged.
- R3: While enabled with divisor D, `tick16_o` is high for exactly one reference cycle in every D+1 cycles.
- R4: A divisor of 0 makes `tick16_o` high on every enabled cycle.
- R5: While `en` is low, no tick or strobe is produced and the counter holds the divisor. After `en` rises, the first tick comes D clock edges later.
- R6: A divisor write made while a period is running does not change that period. The new value sets the length of the period after it.
- R7: `bit_stb_o` is high only together with a tick, on every 16th tick counted from when enable rose, so its period is 16×(D+1) cycles.
- R8: Writes to both bytes in the same cycle load the full 16-bit divisor at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables tick generation |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| div_lo_wdata | input | 8 | Data for divisor bits 7:0 |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 |
| div_hi_wdata | input | 8 | Data for divisor bits 15:8 |
| tick16_o | output | 1 | One-cycle tick at 16× the bit rate |
| bit_stb_o | output | 1 | One-cycle strobe at the bit rate |

## Verification
A divisor write and a counter reload can land in the same cycle, or a write can come in the middle of a period. The bench provokes this by writing a new divisor a few cycles after a tick. It then expects the next gap between ticks to follow the old divisor and the gap after that to follow the new one. Random divisors are loaded with both bytes in one cycle or in two separate cycles. Every gap between ticks is measured at the ports and compared with D+1.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BAUD_BYTE_W  = 8;
  localparam int BAUD_LANES   = 2;
  localparam int BAUD_SUB_W   = 4;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int BYTE_W   = baud_pkg::BAUD_BYTE_W,
  parameter int LANES    = baud_pkg::BAUD_LANES,
  parameter int LO_RESET = 0,
  localparam int DIV_W   = BYTE_W * LANES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             lane_we,
  input  logic [LANES-1:0][BYTE_W-1:0] lane_wd,
  output logic [DIV_W-1:0]             div_q
);
  logic [LANES-1:0][BYTE_W-1:0] lane_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [BYTE_W-1:0] RST = (g == 0) ? BYTE_W'(LO_RESET) : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q[g] <= RST;
      else if (lane_we[g]) lane_q[g] <= lane_wd[g];
    end

    a_r2_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[g] |=> lane_q[g] == $past(lane_wd[g]));
    a_r2_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_we[g] |=> $stable(lane_q[g]));
  end

  assign div_q = lane_q;
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int DIV_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             cnt_zero;

  function automatic logic [DIV_W-1:0] cnt_next(input logic enable,
                                                input logic [DIV_W-1:0] cur,
                                                input logic [DIV_W-1:0] div);
    if (!enable || cur == '0) return div;
    return cur - DIV_W'(1);
  endfunction

  assign cnt_zero = (cnt_q == '0);
  assign tick_o   = en && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= DIV_W'(RST_VAL);
    else        cnt_q <= cnt_next(en, cnt_q, div_i);
  end

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(div_i));
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> !tick_o);
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_zero) |=> cnt_q == $past(cnt_q) - DIV_W'(1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == $past(div_i));
  a_r4_zero_every: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_i == '0 && cnt_zero) |=> (cnt_zero));
endmodule

// File: rtl/baud_bit_divider.sv
module baud_bit_divider #(
  parameter int SUB_W = baud_pkg::BAUD_SUB_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick_i,
  output logic stb_o
);
  logic [SUB_W-1:0] sub_q;

  function automatic logic [SUB_W-1:0] sub_next(input logic enable,
                                                input logic t,
                                                input logic [SUB_W-1:0] cur);
    if (!enable) return '0;
    if (t)       return cur + SUB_W'(1);
    return cur;
  endfunction

  assign stb_o = tick_i && (sub_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_next(en, tick_i, sub_q);
  end

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> sub_q == '0);
  a_r7_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_i && !stb_o) |=> sub_q == $past(sub_q) + SUB_W'(1));
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sub_q == '0);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int LO_RESET = 0,
  localparam int BYTE_W  = baud_pkg::BAUD_BYTE_W,
  localparam int LANES   = baud_pkg::BAUD_LANES,
  localparam int DIV_W   = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              div_lo_we,
  input  logic [BYTE_W-1:0] div_lo_wdata,
  input  logic              div_hi_we,
  input  logic [BYTE_W-1:0] div_hi_wdata,
  output logic              tick16_o,
  output logic              bit_stb_o
);
  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][BYTE_W-1:0] lane_wd;
  logic [DIV_W-1:0]             div_w;
  logic                         tick_w;

  assign lane_we = {div_hi_we, div_lo_we};
  assign lane_wd = {div_hi_wdata, div_lo_wdata};

  baud_div_regs #(.BYTE_W(BYTE_W), .LANES(LANES), .LO_RESET(LO_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .lane_wd(lane_wd), .div_q(div_w));

  baud_down_counter #(.DIV_W(DIV_W), .RST_VAL(LO_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .div_i(div_w), .tick_o(tick_w));

  baud_bit_divider #(.SUB_W(baud_pkg::BAUD_SUB_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_i(tick_w), .stb_o(bit_stb_o));

  assign tick16_o = tick_w;

  a_r5_no_tick_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(tick16_o || bit_stb_o));
  a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |-> tick16_o);
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] lo_d = '0, hi_d = '0;
  logic tick, bstb;
  int checks = 0;
  int fails = 0;
  localparam int LIM = 5000;

  always #4 clk = ~clk;

  baud_tick_gen u0 (.clk(clk), .rst_n(rst_n), .en(en),
    .div_lo_we(lo_we), .div_lo_wdata(lo_d), .div_hi_we(hi_we), .div_hi_wdata(hi_d),
    .tick16_o(tick), .bit_stb_o(bstb));

  function automatic int exp_period(input int d);
    return d + 1;
  endfunction

  function automatic bit exp_strobe(input int tick_idx);
    return (tick_idx % 16) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_div(input int d, input bit same_cycle);
    @(negedge clk);
    lo_d = d[7:0]; hi_d = d[15:8];
    if (same_cycle) begin
      lo_we = 1'b1; hi_we = 1'b1;
      @(negedge clk); lo_we = 1'b0; hi_we = 1'b0;
    end else begin
      hi_we = 1'b1;
      @(negedge clk); hi_we = 1'b0; lo_we = 1'b1;
      @(negedge clk); lo_we = 1'b0;
    end
  endtask

  task automatic first_tick(output int n);
    n = 0;
    while (!tick && n < LIM) begin @(negedge clk); n++; end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < LIM);
  endtask

  task automatic enable_now();
    @(negedge clk); @(negedge clk);
    en = 1'b1;
  endtask

  task automatic disable_now();
    @(negedge clk); en = 1'b0;
  endtask

  task automatic run_periods(input int d, input string req, input int reps);
    int n;
    enable_now();
    first_tick(n);
    check(n == d, "R5 first tick", n, d);
    for (int k = 0; k < reps; k++) begin
      next_tick(n);
      check(n == exp_period(d), req, n, exp_period(d));
    end
    disable_now();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int n, seen, d1, d2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && bstb == 1'b0, "R1 outputs low in reset", {tick, bstb}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && bstb == 1'b0, "R1 outputs low after reset", {tick, bstb}, 0);

    // R1/R4: reset divisor is 0 -> tick every enabled cycle
    en = 1'b1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); seen += tick; end
    check(seen == 8, "R4 tick every cycle with divisor 0", seen, 8);
    disable_now();

    // R5: disabled stays quiet
    write_div(5, 1'b1);
    seen = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); seen += tick + bstb; end
    check(seen == 0, "R5 no output while disabled", seen, 0);

    // R3 directed: 9600 baud at 7.3728 MHz
    write_div(47, 1'b0);
    run_periods(47, "R3 period D+1", 4);

    // R2 high byte only
    write_div(47, 1'b1);
    @(negedge clk); hi_d = 8'h01; hi_we = 1'b1;
    @(negedge clk); hi_we = 1'b0;
    run_periods(16'h012F, "R2 high byte write", 2);
    @(negedge clk); lo_d = 8'h02; lo_we = 1'b1;
    @(negedge clk); lo_we = 1'b0;
    run_periods(16'h0102, "R2 low byte write keeps high", 1);

    // R8 / R3 random divisors
    for (int i = 0; i < 8; i++) begin
      d1 = int'($urandom_range(0, 300));
      write_div(d1, i[0]);
      run_periods(d1, i[0] ? "R8 same-cycle write period" : "R3 random period", 3);
    end

    // R6 write during a running period
    d1 = 20; d2 = 7;
    write_div(d1, 1'b1);
    enable_now();
    first_tick(n);
    repeat (5) @(negedge clk);
    lo_d = 8'(d2); hi_d = 8'h00; lo_we = 1'b1; hi_we = 1'b1;
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b0;
    next_tick(n);
    check(n == exp_period(d1) - 6, "R6 current period unchanged", n, exp_period(d1) - 6);
    next_tick(n);
    check(n == exp_period(d2), "R6 new divisor next period", n, exp_period(d2));
    disable_now();

    // R7 bit strobe every 16th tick
    write_div(3, 1'b1);
    enable_now();
    seen = 0;
    for (int k = 1; k <= 48; k++) begin
      if (k == 1) first_tick(n); else next_tick(n);
      if (bstb != exp_strobe(k)) seen++;
    end
    check(seen == 0, "R7 strobe on 16th tick", seen, 0);
    n = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); if (bstb && !tick) n++; end
    check(n == 0, "R7 strobe only with tick", n, 0);
    disable_now();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule